// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Software talks to it through a small byte-wide register port. One register holds the start bit and a read-only busy flag. The others hold a 3-bit converter clock-divide code, four analog-enable bits for port pins 0 to 3, and an interrupt request flag with its enable. The comparator, the trial DAC and the pin multiplexing sit outside the block. They appear here only as a comparator input bit, a trial-code output and the pin-enable outputs.

To convert, software writes the start bit to 1 and then back to 0. The block sees the falling edge and begins. It tests one result bit per converter clock, from the most significant bit down. When the last bit is settled it publishes the result, clears the busy flag and raises the interrupt request. A start bit that is left at 1 holds the converter in reset with the busy flag at 1. A fresh start pulse given during a conversion abandons that conversion and begins again from the top bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion begins only on a 1-to-0 transition of START that follows a 0-to-1 transition. START is bit 7 of address 0, readable and writable. While the conversion runs, EOCB reads 1. EOCB is bit 6 of address 0 and is read-only; all other bits of address 0 read 0.
- R2: From the clock edge after START is seen at 1, and for as long as START stays 1, three things hold: EOCB is 1, no conversion runs, and the trial code output is 0.
- R3: With divide ratio D, EOCB falls on the (12·D+1)-th clock edge after the edge that writes START back to 0. EOCB then stays 0 until START is next set.
- R4: At the end of every conversion the request flag (address 3, bit 0) is set. The irq output is the flag ANDed with the enable (address 3, bit 1). A write to address 3 with bit 0 at 0 clears the flag, and bit 0 at 1 leaves it unchanged. When a conversion ends on the same edge as a clearing write, the flag stays set.
- R5: The divide code is bits 2:0 of address 1. Codes 0 to 6 select a ratio of 2^code, and code 7 selects a ratio of 1. Bits 7:3 of address 1 read 0.
- R6: Each bit decision occupies D system clocks, working from the MSB down. The trial code equals the bits already decided plus a 1 in the bit under test. The comparator input at 1 keeps that bit. The result output changes only on the edge where EOCB falls.
- R7: The pin-enable bits are bits 3:0 of address 2 and drive pin_analog, where 1 means analog input. They reset to 1111, and bits 7:4 read 0.
- R8: A START pulse during a conversion abandons it. The result stays unchanged, and the new conversion starts from the MSB after the falling edge.
- R9: After reset: START is 0, EOCB is 1, the result is 0, the divide code is 0, and the flag, the enable and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code | output | 12 | Trial code for the DAC; 0 when no conversion runs |
| result | output | 12 | Last completed conversion result |
| eoc_busy | output | 1 | Busy / end-of-conversion flag (EOCB) |
| irq | output | 1 | Interrupt request, gated by the enable |
| pin_analog | output | 4 | Per-pin analog-input enables |

## Verification
The hardest state to reach is an abort. That needs a second complete rise-and-fall of START in the middle of a running conversion, with the comparator input changed between the two. The bench gets there by launching a conversion against one input value and letting a few bit decisions settle. It then pulses START and changes the modelled analog value, and checks that the old result survives and that the new result matches the second value. A second hard case is a clearing write to the flag on the exact edge where a conversion ends. The bench times that write from the cycle count given in R3.

// File: rtl/adc_seq_pkg.sv
// Package: register addresses and bit positions shared by the sequencer
// and its bench-visible register map.
package adc_seq_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CLK  = 2'd1;
    localparam logic [1:0] ADDR_PIN  = 2'd2;
    localparam logic [1:0] ADDR_IRQ  = 2'd3;
    localparam int START_POS = 7;
    localparam int BUSY_POS  = 6;
    localparam int FLAG_POS  = 0;
    localparam int IEN_POS   = 1;
endpackage

// File: rtl/adc_clk_div.sv
// Converter clock divider.
// Produces a one-cycle tick every 2^code system clocks while run is high;
// the all-ones code selects a tick every clock. The count restarts whenever
// run is low, so the first tick of a conversion comes a full period late.
// Assumes CODE_W >= 2 and that code is held steady during a conversion.
module adc_clk_div #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W) - 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Terminal count: 2^code - 1, or 0 for the all-ones code.
    always_comb begin
        limit = '0;
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (code != '1) && (CODE_W'(i) < code);
        end
    end

    assign tick = run && (cnt == limit);

    // Period counter, held at zero outside a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
endmodule

// File: rtl/adc_start_detect.sv
// Start handshake detector.
// Watches the registered start bit. A rise arms the detector, and a fall
// while armed gives a one-cycle launch pulse. hold mirrors the start bit so
// that the converter stays in reset while it is high.
module adc_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic start_bit,
    output logic hold,
    output logic launch
);
    logic start_d;
    logic armed;

    assign hold   = start_bit;
    assign launch = armed && start_d && !start_bit;

    // Delayed copy of start and the armed marker set by a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            armed   <= 1'b0;
        end else begin
            start_d <= start_bit;
            if (start_bit && !start_d) begin
                armed <= 1'b1;
            end else if (launch) begin
                armed <= 1'b0;
            end
        end
    end

    assert_launch_after_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> ($past(start_bit) && !start_bit));
    assert_launch_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);
endmodule

// File: rtl/adc_sar_engine.sv
// Successive-approximation engine.
// On launch it clears the partial result and starts at the MSB. On each
// divider tick it keeps or drops the bit under test according to cmp_in.
// After the LSB it publishes the result and drops the busy flag. hold
// forces it idle with busy high. Assumes hold and launch are never high
// together.
module adc_sar_engine #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             launch,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             running,
    output logic             done,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] sar;

    assign done     = running && tick && (idx == '0);
    assign dac_code = running ? (sar | (RES_W'(1) << idx)) : '0;

    // Conversion state, partial result, busy flag and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            idx     <= '0;
            sar     <= '0;
            busy    <= 1'b1;
            result  <= '0;
        end else if (hold) begin
            running <= 1'b0;
            sar     <= '0;
            busy    <= 1'b1;
        end else if (launch) begin
            running <= 1'b1;
            idx     <= TOP_IDX;
            sar     <= '0;
            busy    <= 1'b1;
        end else if (running && tick) begin
            sar[idx] <= cmp_in;
            if (idx == '0) begin
                running <= 1'b0;
                busy    <= 1'b0;
                result  <= {sar[RES_W-1:1], cmp_in};
            end else begin
                idx <= idx - 1'b1;
            end
        end
    end

    assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (busy && !running));
    assert_launch_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (running && busy && idx == TOP_IDX));
    assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && idx != '0 && !hold) |=> (idx == $past(idx) - 1'b1));
    assert_result_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> $fell(busy));
    assert_done_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hold) |=> !busy);
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion control sequencer, top level.
// Holds the software registers: start, divide code, pin enables, and the
// interrupt flag with its enable. It wires the start detector, the divider
// and the SAR engine together. Register reads are combinational from
// reg_addr. Reset is synchronous and active low.
module adc_seq_ctrl #(
    parameter int RES_W  = 12,
    parameter int CODE_W = 3,
    parameter int NPIN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             eoc_busy,
    output logic             irq,
    output logic [NPIN-1:0]  pin_analog
);
    import adc_seq_pkg::*;

    logic              start_reg;
    logic [CODE_W-1:0] code_reg;
    logic [NPIN-1:0]   pin_reg;
    logic              irq_flag;
    logic              irq_en;
    logic              hold, launch, tick, running, done;
    logic              wr_ctrl, wr_clk, wr_pin, wr_irq;
    logic              unused_wbits;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_clk  = reg_wr && (reg_addr == ADDR_CLK);
    assign wr_pin  = reg_wr && (reg_addr == ADDR_PIN);
    assign wr_irq  = reg_wr && (reg_addr == ADDR_IRQ);
    assign unused_wbits = ^reg_wdata[6:4];

    // Software-writable configuration and start registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_reg <= 1'b0;
            code_reg  <= '0;
            pin_reg   <= '1;
            irq_en    <= 1'b0;
        end else begin
            if (wr_ctrl) start_reg <= reg_wdata[START_POS];
            if (wr_clk)  code_reg  <= reg_wdata[CODE_W-1:0];
            if (wr_pin)  pin_reg   <= reg_wdata[NPIN-1:0];
            if (wr_irq)  irq_en    <= reg_wdata[IEN_POS];
        end
    end

    // Interrupt request flag: set by end of conversion, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (done && !hold) begin
            irq_flag <= 1'b1;
        end else if (wr_irq && !reg_wdata[FLAG_POS]) begin
            irq_flag <= 1'b0;
        end
    end

    // Read multiplexer; unimplemented bits read 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[START_POS] = start_reg;
                reg_rdata[BUSY_POS]  = eoc_busy;
            end
            ADDR_CLK: reg_rdata[CODE_W-1:0] = code_reg;
            ADDR_PIN: reg_rdata[NPIN-1:0]   = pin_reg;
            default: begin
                reg_rdata[FLAG_POS] = irq_flag;
                reg_rdata[IEN_POS]  = irq_en;
            end
        endcase
    end

    assign irq        = irq_flag && irq_en;
    assign pin_analog = pin_reg;

    adc_start_detect u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_bit (start_reg),
        .hold      (hold),
        .launch    (launch)
    );

    adc_clk_div #(.CODE_W(CODE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .code  (code_reg),
        .tick  (tick)
    );

    adc_sar_engine #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .launch   (launch),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .busy     (eoc_busy),
        .running  (running),
        .done     (done),
        .dac_code (dac_code),
        .result   (result)
    );

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hold) |=> irq_flag);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(wr_irq && !reg_wdata[FLAG_POS])) |=> irq_flag);
    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: tb/adc_seq_ctrl_test.sv
// Bench: behavioural per-cycle model compared with the outputs on every clock.
module adc_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        cmp_in;
    logic [11:0] dac_code, result;
    logic        eoc_busy, irq;
    logic [3:0]  pin_analog;
    logic [11:0] vin = 12'd0;

    int checks = 0;
    int errors = 0;
    bit chk_en = 0;

    // model state
    int m_start, m_start_d, m_eocb, m_result, m_conv, m_phase, m_acc;
    int m_code, m_pins, m_flag, m_en;

    always #5 clk = ~clk;
    assign cmp_in = (vin >= dac_code);

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .result(result), .eoc_busy(eoc_busy),
        .irq(irq), .pin_analog(pin_analog)
    );

    function automatic int ratio_of(int c);
        return (c == 7) ? 1 : (1 << c);
    endfunction

    function automatic int exp_dac();
        if (m_conv == 0) return 0;
        return m_acc | (1 << (11 - m_phase / ratio_of(m_code)));
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_start_d = 0; m_eocb = 1; m_result = 0; m_conv = 0;
            m_phase = 0; m_acc = 0; m_code = 0; m_pins = 15; m_flag = 0; m_en = 0;
            chk_en = 1;
        end else begin
            int r, b, trial, setf, nstart;
            r = ratio_of(m_code);
            setf = 0;
            if (m_start != 0) begin
                m_conv = 0; m_eocb = 1;
            end else if (m_start_d != 0) begin
                m_conv = 1; m_phase = 0; m_acc = 0; m_eocb = 1;
            end else if (m_conv != 0) begin
                b = 11 - m_phase / r;
                if ((m_phase + 1) % r == 0) begin
                    trial = m_acc | (1 << b);
                    if (int'(vin) >= trial) m_acc = trial;
                    if (b == 0) begin
                        m_conv = 0; m_eocb = 0; m_result = m_acc; setf = 1;
                    end
                end
                m_phase++;
            end
            nstart = m_start;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: nstart = reg_wdata[7];
                    2'd1: m_code = reg_wdata[2:0];
                    2'd2: m_pins = reg_wdata[3:0];
                    default: begin
                        m_en = reg_wdata[1];
                        if (!reg_wdata[0]) m_flag = 0;
                    end
                endcase
            end
            if (setf != 0) m_flag = 1;
            m_start_d = m_start;
            m_start = nstart;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check("R3", eoc_busy, m_eocb, "eocb");
            check("R6", result, m_result, "result");
            check("R6", dac_code, exp_dac(), "trial code");
            check("R4", irq, m_flag & m_en, "irq");
            check("R7", pin_analog, m_pins, "pin enables");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp, "register read");
    endtask

    // Pulse START and count edges until EOCB falls (R3 timing).
    task automatic convert(input int code, input logic [11:0] v, input string tag);
        int n;
        vin = v;
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h00);
        n = 0;
        while (eoc_busy && n < 2000) begin
            @(posedge clk); #1; n++;
        end
        check(tag, n, 12 * ratio_of(code) + 1, "edges to EOCB fall");
        check("R6", result, v, "conversion result");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd(2'd0, 8'h40, "R9");
        rd(2'd1, 8'h00, "R9");
        rd(2'd3, 8'h00, "R9");
        check("R9", result, 0, "reset result");
        // R7 pin register
        rd(2'd2, 8'h0F, "R7");
        wr(2'd2, 8'hA5);
        rd(2'd2, 8'h05, "R7");
        check("R7", pin_analog, 5, "pin_analog");
        // R1 basic conversion, code 0
        convert(0, 12'hABC, "R1");
        rd(2'd0, 8'h00, "R1");
        // R4 flag set with enable off; irq stays 0
        check("R4", irq, 0, "irq gated off");
        rd(2'd3, 8'h01, "R4");
        wr(2'd3, 8'h03);
        check("R4", irq, 1, "irq enabled");
        wr(2'd3, 8'h02);
        check("R4", irq, 0, "flag cleared");
        // R5 divide codes
        wr(2'd1, 8'hF9);
        rd(2'd1, 8'h01, "R5");
        convert(1, 12'h000, "R5");
        wr(2'd1, 8'h03);
        convert(3, 12'hFFF, "R5");
        wr(2'd1, 8'h07);
        convert(7, 12'h555, "R5");
        wr(2'd1, 8'h06);
        convert(6, 12'h801, "R5");
        check("R4", irq, 1, "irq after conversion");
        // R2 hold while START high
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h80);
        repeat (20) @(negedge clk);
        check("R2", eoc_busy, 1, "busy while held");
        check("R2", dac_code, 0, "no trial while held");
        rd(2'd0, 8'hC0, "R2");
        wr(2'd0, 8'h00);
        repeat (14) @(negedge clk);
        // R8 abort mid-conversion
        wr(2'd1, 8'h02);
        vin = 12'h3C7;
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h00);
        repeat (9) @(negedge clk);
        vin = 12'h9E2;
        wr(2'd0, 8'h80);
        check("R8", result, 12'h801, "result kept on abort");
        wr(2'd0, 8'h00);
        repeat (60) @(negedge clk);
        check("R8", result, 12'h9E2, "restarted result");
        // R4 clear on the same edge as end of conversion: set wins
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h02);
        vin = 12'h123;
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h00);
        repeat (12) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h02;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R4", irq, 1, "set wins over clear");
        check("R6", result, 12'h123, "result");
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual still running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule